// File: doc/BRIEF.md
# In-Order Commit Reorder Buffer

This block is a circular queue that sits between instruction dispatch and architectural state in an out-of-order core. Each dispatched instruction is given one slot, in program order, and the slot index goes back to the dispatcher. Execution units later name that index when they finish, and the result is parked in the slot. Results leave the block one at a time from the oldest slot. The oldest slot leaves only after its result has arrived, so an older instruction that is still running holds back younger ones that have already finished.

When a branch turns out to be mispredicted, the branch's slot index is presented on the flush port. Every slot younger than the branch is dropped together with any result it holds, and the allocation pointer rewinds to the slot just after the branch. The branch and every older slot stay in place and still retire in order. A speculative result therefore never reaches the commit port unless the branch ahead of it was confirmed.

Top module: `rob_inorder_commit`

## Requirements
- R1: After synchronous reset the buffer is empty: `disp_ready` is 1, `cmt_valid` is 0 and `disp_idx` is 0.
- R2: Each accepted dispatch takes the slot shown on `disp_idx` in that cycle. Successive dispatches get consecutive indices modulo DEPTH.
- R3: Once DEPTH slots are occupied, `disp_ready` is 0, and a dispatch presented in that state allocates nothing and never appears on the commit port.
- R4: `cmt_valid` stays 0 while the oldest slot has no result, even if younger slots already hold results.
- R5: Slots retire in allocation order, and each retirement presents the tag given at dispatch and the data given at completion.
- R6: A completion that targets the oldest slot makes that slot retire in the same cycle, with the completion data on `cmt_data`.
- R7: At most one slot retires per cycle, and `cmt_valid` is 0 whenever the buffer is empty.
- R8: A flush naming an occupied slot discards every younger slot, which then never retires. The next dispatch gets index flush_idx+1 modulo DEPTH.
- R9: The flushed branch slot and all slots older than it remain and retire in order after the flush.
- R10: `disp_ready` is 0 in any cycle where `flush_valid` is 1.
- R11: A completion naming a slot that is not waiting for a result is ignored. A slot allocated there later still waits for its own completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request |
| disp_tag | input | TAG_W | Destination tag of the dispatched instruction |
| disp_ready | output | 1 | A slot is free and no flush is in progress |
| disp_idx | output | IDX_W | Slot index given to the dispatch |
| cmpl_valid | input | 1 | Completion strobe from an execution unit |
| cmpl_idx | input | IDX_W | Slot being completed |
| cmpl_data | input | DATA_W | Result value |
| cmt_ready | input | 1 | Architectural state accepts a retirement this cycle |
| cmt_valid | output | 1 | Oldest slot is complete and can retire |
| cmt_tag | output | TAG_W | Destination tag of the retiring slot |
| cmt_data | output | DATA_W | Result of the retiring slot |
| flush_valid | input | 1 | Mispredicted-branch flush request |
| flush_idx | input | IDX_W | Slot index of the mispredicted branch |

## Verification
The bench completes slots out of order and checks that a finished younger slot does not retire past an unfinished head. A design that retires by completion order would leak results early. It also drives a completion into the head slot while the consumer is ready, which catches a design that needs an extra cycle or retires stale data. The buffer is filled to capacity and one more dispatch is offered: a wrong full test would overwrite the oldest slot or drop a retirement. A flush lands in the middle of a wrapped window, after which the bench fires a stale completion at a discarded slot and reuses that slot. A design that rewinds the pointer wrongly, keeps a discarded entry, or lets a stale result mark the new occupant finished would then retire the wrong tag or retire too soon.

// File: rtl/rob_pkg.sv
package rob_pkg;

    // Life cycle of one buffer slot
    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_WAIT = 2'd1,
        SLOT_DONE = 2'd2
    } slot_state_e;

    // Per-cycle handshake outcomes shared between the sub-blocks
    typedef struct packed {
        logic disp_fire;
        logic cmt_fire;
        logic flush_ok;
    } rob_ctrl_t;

    // Distance of a slot from the head, wrapping modulo the ring size
    function automatic logic [15:0] ring_dist(input logic [15:0] slot,
                                              input logic [15:0] head,
                                              input logic [15:0] mask);
        return (slot - head) & mask;
    endfunction

endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  rob_pkg::rob_ctrl_t ctrl,
    input  logic [IDX_W-1:0] flush_off,
    output logic [PTR_W-1:0] head_ptr,
    output logic [PTR_W-1:0] tail_ptr,
    output logic [PTR_W-1:0] count,
    output logic             full,
    output logic             empty
);
    logic [PTR_W-1:0] head_q, tail_q;
    logic [PTR_W-1:0] head_d, tail_d;

    always_comb begin
        head_d = head_q;
        tail_d = tail_q;
        if (ctrl.cmt_fire)
            head_d = head_q + 1'b1;
        if (ctrl.flush_ok)
            // rewind to the slot right after the branch, measured from the old head
            tail_d = head_q + {1'b0, flush_off} + 1'b1;
        else if (ctrl.disp_fire)
            tail_d = tail_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            head_q <= head_d;
            tail_q <= tail_d;
        end
    end

    assign head_ptr = head_q;
    assign tail_ptr = tail_q;
    assign count    = tail_q - head_q;
    assign full     = (count == PTR_W'(DEPTH));
    assign empty    = (count == '0);
endmodule

// File: rtl/rob_flush_mask.sv
module rob_flush_mask #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic             flush_valid,
    input  logic [IDX_W-1:0] flush_idx,
    input  logic [IDX_W-1:0] head_idx,
    input  logic [PTR_W-1:0] count,
    output logic             flush_ok,
    output logic [IDX_W-1:0] flush_off,
    output logic [DEPTH-1:0] kill_mask
);
    localparam logic [15:0] RING_MASK = 16'(DEPTH - 1);

    assign flush_off = IDX_W'(rob_pkg::ring_dist(16'(flush_idx), 16'(head_idx), RING_MASK));
    // only a branch inside the occupied window may trigger a purge
    assign flush_ok  = flush_valid && ({1'b0, flush_off} < count);

    for (genvar i = 0; i < DEPTH; i++) begin : g_kill
        logic [IDX_W-1:0] dist_i;
        assign dist_i = IDX_W'(rob_pkg::ring_dist(16'(i), 16'(head_idx), RING_MASK));
        assign kill_mask[i] = flush_ok && (dist_i > flush_off);
    end
endmodule

// File: rtl/rob_slot_array.sv
module rob_slot_array #(
    parameter int DEPTH  = 8,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_we,
    input  logic [IDX_W-1:0]  alloc_idx,
    input  logic [TAG_W-1:0]  alloc_tag,
    input  logic              cmpl_valid,
    input  logic [IDX_W-1:0]  cmpl_idx,
    input  logic [DATA_W-1:0] cmpl_data,
    input  logic              retire_we,
    input  logic [IDX_W-1:0]  retire_idx,
    input  logic [DEPTH-1:0]  kill_mask,
    input  logic [IDX_W-1:0]  rd_idx,
    output rob_pkg::slot_state_e rd_state,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data
);
    import rob_pkg::*;

    slot_state_e       state_a [DEPTH];
    logic [TAG_W-1:0]  tag_a   [DEPTH];
    logic [DATA_W-1:0] data_a  [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic hit_alloc, hit_cmpl, hit_retire;
        assign hit_alloc  = alloc_we   && (alloc_idx  == IDX_W'(i));
        assign hit_cmpl   = cmpl_valid && (cmpl_idx   == IDX_W'(i)) && (state_a[i] == SLOT_WAIT);
        assign hit_retire = retire_we  && (retire_idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                state_a[i] <= SLOT_FREE;
                tag_a[i]   <= '0;
                data_a[i]  <= '0;
            end else if (kill_mask[i] || hit_retire) begin
                state_a[i] <= SLOT_FREE;
            end else if (hit_alloc) begin
                state_a[i] <= SLOT_WAIT;
                tag_a[i]   <= alloc_tag;
            end else if (hit_cmpl) begin
                state_a[i] <= SLOT_DONE;
                data_a[i]  <= cmpl_data;
            end
        end
    end

    assign rd_state = state_a[rd_idx];
    assign rd_tag   = tag_a[rd_idx];
    assign rd_data  = data_a[rd_idx];
endmodule

// File: rtl/rob_inorder_commit.sv
module rob_inorder_commit #(
    parameter int DEPTH  = 8,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              disp_valid,
    input  logic [TAG_W-1:0]  disp_tag,
    output logic              disp_ready,
    output logic [IDX_W-1:0]  disp_idx,
    input  logic              cmpl_valid,
    input  logic [IDX_W-1:0]  cmpl_idx,
    input  logic [DATA_W-1:0] cmpl_data,
    input  logic              cmt_ready,
    output logic              cmt_valid,
    output logic [TAG_W-1:0]  cmt_tag,
    output logic [DATA_W-1:0] cmt_data,
    input  logic              flush_valid,
    input  logic [IDX_W-1:0]  flush_idx
);
    import rob_pkg::*;

    rob_ctrl_t        ctrl;
    logic [PTR_W-1:0] head_ptr, tail_ptr, count;
    logic             full, empty;
    logic [IDX_W-1:0] head_idx, flush_off;
    logic [DEPTH-1:0] kill_mask;
    logic             flush_ok;
    slot_state_e      head_state;
    logic [TAG_W-1:0] head_tag;
    logic [DATA_W-1:0] head_data;
    logic             head_bypass;

    assign head_idx = head_ptr[IDX_W-1:0];
    assign disp_idx = tail_ptr[IDX_W-1:0];

    // a flush owns the allocation pointer for its cycle
    assign disp_ready = !full && !flush_valid;

    // completion to the head is folded in before the retire decision
    assign head_bypass = cmpl_valid && (cmpl_idx == head_idx) && (head_state == SLOT_WAIT);
    assign cmt_valid   = !empty && ((head_state == SLOT_DONE) || head_bypass);
    assign cmt_tag     = head_tag;
    assign cmt_data    = head_bypass ? cmpl_data : head_data;

    assign ctrl.disp_fire = disp_valid && disp_ready;
    assign ctrl.cmt_fire  = cmt_valid && cmt_ready;
    assign ctrl.flush_ok  = flush_ok;

    rob_ptr_ctrl #(.DEPTH(DEPTH)) ptr_i (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .flush_off (flush_off),
        .head_ptr  (head_ptr),
        .tail_ptr  (tail_ptr),
        .count     (count),
        .full      (full),
        .empty     (empty)
    );

    rob_flush_mask #(.DEPTH(DEPTH)) mask_i (
        .flush_valid (flush_valid),
        .flush_idx   (flush_idx),
        .head_idx    (head_idx),
        .count       (count),
        .flush_ok    (flush_ok),
        .flush_off   (flush_off),
        .kill_mask   (kill_mask)
    );

    rob_slot_array #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W)) slots_i (
        .clk        (clk),
        .rst        (rst),
        .alloc_we   (ctrl.disp_fire),
        .alloc_idx  (disp_idx),
        .alloc_tag  (disp_tag),
        .cmpl_valid (cmpl_valid),
        .cmpl_idx   (cmpl_idx),
        .cmpl_data  (cmpl_data),
        .retire_we  (ctrl.cmt_fire),
        .retire_idx (head_idx),
        .kill_mask  (kill_mask),
        .rd_idx     (head_idx),
        .rd_state   (head_state),
        .rd_tag     (head_tag),
        .rd_data    (head_data)
    );
endmodule

module rob_inorder_commit_chk #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             disp_valid,
    input logic             disp_ready,
    input logic [IDX_W-1:0] disp_idx,
    input logic             cmt_valid,
    input logic             cmt_ready,
    input logic             flush_ok,
    input logic [IDX_W-1:0] flush_idx,
    input logic [PTR_W-1:0] count,
    input logic [IDX_W-1:0] head_idx
);
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= PTR_W'(DEPTH));

    a_r3_full_refuses: assert property (@(posedge clk) disable iff (rst)
        (count == PTR_W'(DEPTH)) |-> !disp_ready);

    a_r7_empty_quiet: assert property (@(posedge clk) disable iff (rst)
        (count == '0) |-> !cmt_valid);

    a_r2_alloc_grows: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && disp_ready && !(cmt_valid && cmt_ready)) |=> (count == $past(count) + 1'b1));

    a_r5_head_steps: assert property (@(posedge clk) disable iff (rst)
        (cmt_valid && cmt_ready) |=> (head_idx == $past(head_idx) + 1'b1));

    a_r8_tail_rewind: assert property (@(posedge clk) disable iff (rst)
        flush_ok |=> (disp_idx == $past(flush_idx) + 1'b1));

    a_r10_flush_blocks: assert property (@(posedge clk) disable iff (rst)
        flush_ok |-> !disp_ready);
endmodule

bind rob_inorder_commit rob_inorder_commit_chk #(.DEPTH(DEPTH)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .disp_valid (disp_valid),
    .disp_ready (disp_ready),
    .disp_idx   (disp_idx),
    .cmt_valid  (cmt_valid),
    .cmt_ready  (cmt_ready),
    .flush_ok   (flush_ok),
    .flush_idx  (flush_idx),
    .count      (count),
    .head_idx   (head_idx)
);

// File: tb/rob_inorder_commit_tb_top.sv
module rob_inorder_commit_tb_top;
    localparam int DEPTH  = 8;
    localparam int TAG_W  = 8;
    localparam int DATA_W = 32;
    localparam int IDX_W  = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              disp_valid = 1'b0;
    logic [TAG_W-1:0]  disp_tag = '0;
    logic              disp_ready;
    logic [IDX_W-1:0]  disp_idx;
    logic              cmpl_valid = 1'b0;
    logic [IDX_W-1:0]  cmpl_idx = '0;
    logic [DATA_W-1:0] cmpl_data = '0;
    logic              cmt_ready = 1'b0;
    logic              cmt_valid;
    logic [TAG_W-1:0]  cmt_tag;
    logic [DATA_W-1:0] cmt_data;
    logic              flush_valid = 1'b0;
    logic [IDX_W-1:0]  flush_idx = '0;

    int n_checks = 0;
    int n_fails  = 0;
    int committed = 0;
    int tail_m = 0;
    int exp_q[$];
    int idx_of[int];
    bit finished = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    rob_inorder_commit #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst(rst),
        .disp_valid(disp_valid), .disp_tag(disp_tag), .disp_ready(disp_ready), .disp_idx(disp_idx),
        .cmpl_valid(cmpl_valid), .cmpl_idx(cmpl_idx), .cmpl_data(cmpl_data),
        .cmt_ready(cmt_ready), .cmt_valid(cmt_valid), .cmt_tag(cmt_tag), .cmt_data(cmt_data),
        .flush_valid(flush_valid), .flush_idx(flush_idx)
    );

    function automatic logic [DATA_W-1:0] dat(int t);
        return 32'hC0DE_0000 + DATA_W'(t * 7);
    endfunction

    function automatic void chk(bit ok, string req, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endfunction

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic dispatch(int tag);
        disp_valid = 1'b1;
        disp_tag   = TAG_W'(tag);
        #6;
        chk(disp_ready == 1'b1, "R2 ready", disp_ready, 1);
        chk(disp_idx == IDX_W'(tail_m), "R2 index", disp_idx, tail_m);
        exp_q.push_back(tag);
        idx_of[tag] = tail_m;
        tail_m = (tail_m + 1) % DEPTH;
        step();
        disp_valid = 1'b0;
    endtask

    task automatic complete(int tag);
        cmpl_valid = 1'b1;
        cmpl_idx   = IDX_W'(idx_of[tag]);
        cmpl_data  = dat(tag);
        step();
        cmpl_valid = 1'b0;
    endtask

    // monitor: pops the scoreboard on every retirement (R5, R8)
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && cmt_valid && cmt_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5 R8 unexpected retire", cmt_tag, 0);
                end else begin
                    int t;
                    t = exp_q.pop_front();
                    chk(cmt_tag == TAG_W'(t), "R5 R8 retire tag", cmt_tag, t);
                    chk(cmt_data == dat(t), "R5 retire data", cmt_data, dat(t));
                end
                committed++;
            end
        end
    end

    initial begin
        #4_000_000;
        if (!finished) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
        #6;
        // R1 reset state
        chk(disp_ready == 1'b1, "R1 ready", disp_ready, 1);
        chk(cmt_valid == 1'b0, "R1 cmt_valid", cmt_valid, 0);
        chk(disp_idx == '0, "R1 index", disp_idx, 0);
        step();

        // ---- out-of-order completion, in-order retirement ----
        for (int t = 10; t < 14; t++) dispatch(t);
        complete(13);
        complete(11);
        cmt_ready = 1'b1;
        #6;
        chk(cmt_valid == 1'b0, "R4 head unfinished", cmt_valid, 0);
        step();
        cmpl_valid = 1'b1;
        cmpl_idx   = IDX_W'(idx_of[10]);
        cmpl_data  = dat(10);
        #6;
        chk(cmt_valid == 1'b1, "R6 same-cycle retire", cmt_valid, 1);
        chk(cmt_data == dat(10), "R6 bypass data", cmt_data, dat(10));
        step();
        cmpl_valid = 1'b0;
        step();
        #6;
        chk(cmt_valid == 1'b0, "R4 slot 12 pending", cmt_valid, 0);
        step();
        complete(12);
        step();
        step();
        #6;
        chk(committed == 4, "R5 retire count", committed, 4);
        chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
        chk(cmt_valid == 1'b0, "R7 empty quiet", cmt_valid, 0);
        step();

        // ---- fill to capacity ----
        cmt_ready = 1'b0;
        for (int t = 20; t < 28; t++) dispatch(t);
        #6;
        chk(disp_ready == 1'b0, "R3 full refuses", disp_ready, 0);
        disp_valid = 1'b1;
        disp_tag   = 8'd99;
        step();
        disp_valid = 1'b0;
        for (int t = 27; t >= 20; t--) complete(t);
        begin
            int base;
            base = committed;
            cmt_ready = 1'b1;
            repeat (3) step();
            chk(committed - base == 3, "R7 one per cycle", committed - base, 3);
        end
        repeat (8) step();
        #6;
        chk(committed == 12, "R3 refused entry absent", committed, 12);
        chk(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
        chk(cmt_valid == 1'b0, "R7 empty after drain", cmt_valid, 0);
        step();

        // ---- mispredict flush in a wrapped window ----
        cmt_ready = 1'b0;
        for (int t = 30; t < 36; t++) dispatch(t);
        complete(30);
        flush_valid = 1'b1;
        flush_idx   = IDX_W'(idx_of[32]);
        disp_valid  = 1'b1;
        disp_tag    = 8'd98;
        #6;
        chk(disp_ready == 1'b0, "R10 flush blocks dispatch", disp_ready, 0);
        step();
        flush_valid = 1'b0;
        disp_valid  = 1'b0;
        repeat (3) void'(exp_q.pop_back());
        tail_m = (idx_of[32] + 1) % DEPTH;
        // stale completion aimed at the discarded slot of tag 34
        cmpl_valid = 1'b1;
        cmpl_idx   = IDX_W'(idx_of[34]);
        cmpl_data  = 32'hBAD0_BAD0;
        step();
        cmpl_valid = 1'b0;
        dispatch(40);   // R8: index must be branch slot + 1
        dispatch(41);   // reuses the slot hit by the stale completion
        cmt_ready = 1'b1;
        complete(31);
        complete(32);
        complete(40);
        step();
        step();
        #6;
        chk(cmt_valid == 1'b0, "R11 stale completion ignored", cmt_valid, 0);
        chk(committed == 16, "R9 older slots retired", committed, 16);
        step();
        complete(41);
        step();
        #6;
        chk(committed == 17, "R8 only survivors retired", committed, 17);
        chk(exp_q.size() == 0, "R8 scoreboard drained", exp_q.size(), 0);
        chk(cmt_valid == 1'b0, "R7 empty at end", cmt_valid, 0);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule